// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one entry from a flat page table in memory. The requester presents the address, a write flag and a user flag. The block splits the address into a page number and an in-page offset. It then reads the entry at the table base plus four bytes per page number, using a memory port with a request/grant handshake and a separate read-response cycle.

The fetched entry is checked in a fixed order. The first check is the valid flag, the second is the present flag, and the last is the access permission. The block returns either a physical address or one of three fault codes. When an access succeeds, the block marks the entry as referenced. On a write it also marks the entry as dirty. The updated entry goes back to the same memory location, and only when one of those flags actually changed.

Only one translation is in flight at any time. The block takes a new request only while it is idle.

Top module: `pt_walker`

## Requirements
- R1: The entry read is issued at address `table_base + (vaddr[31:12] << 2)`. The request stays asserted, with a stable address and `mem_we` low, until `mem_gnt`.
- R2: On success, `rsp_fault` is 0 and `rsp_paddr` is the entry's bits [31:12] placed above `vaddr[11:0]`. On any fault, `rsp_paddr` is 0.
- R3: An entry with bit 0 (valid) clear gives fault code 1, whatever its other bits hold.
- R4: An entry with bit 0 set and bit 1 (present) clear gives fault code 2, whatever its permission bits hold.
- R5: A valid, present entry gives fault code 3 when a write meets bit 2 (write allowed) clear, or when a user access meets bit 3 (user allowed) clear. If neither condition holds, the access succeeds.
- R6: A successful access sets bit 4 (referenced). A write also sets bit 5 (dirty). The updated entry is written to the same address it was read from, once.
- R7: No write is issued when the flags to be set are already set, and none is issued on any fault.
- R8: `req_ready` is high only while the block is idle. A `req_valid` that arrives while `req_ready` is low is ignored and produces no response.
- R9: `rsp_valid` is a one-cycle pulse. Assume the grant arrives at once and the read data comes one cycle after the read grant. Then the pulse appears three clock edges after the accepting edge. A write-back adds one edge, and each cycle of waiting for a grant adds one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| table_base | input | 32 | Byte address of page-table entry 0 |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user level |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 2 | 0 ok, 1 invalid, 2 not present, 3 permission |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory grant for the current request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read data |

## Verification
The bench counts clock edges from the accepting edge. It expects the response exactly 4 negative-edge samples later when there is no write-back. Each write-back adds one sample, and each grant-wait cycle that the memory model inserts adds one more. The read and write requests are checked against the head of the scoreboard queue in the sample where grant is seen. The bench also injects a request while the block is busy. Any response that arrives with an empty queue is reported as a failure.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    // Result codes, ordered by check priority
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_ABSENT  = 2'd2,
        FLT_PERM    = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_CHECK,
        ST_WRITE,
        ST_DONE
    } walk_state_e;

    // Flag positions inside an entry
    localparam int unsigned FLAG_W      = 6;
    localparam int unsigned BIT_VALID   = 0;
    localparam int unsigned BIT_PRESENT = 1;
    localparam int unsigned BIT_WR_OK   = 2;
    localparam int unsigned BIT_USER_OK = 3;
    localparam int unsigned BIT_REF     = 4;
    localparam int unsigned BIT_DIRTY   = 5;

    typedef struct packed {
        logic dirty;
        logic referenced;
        logic user_ok;
        logic wr_ok;
        logic present;
        logic valid;
    } entry_flags_t;

    function automatic entry_flags_t unpack_flags(input logic [FLAG_W-1:0] raw);
        entry_flags_t f;
        f.valid      = raw[BIT_VALID];
        f.present    = raw[BIT_PRESENT];
        f.wr_ok      = raw[BIT_WR_OK];
        f.user_ok    = raw[BIT_USER_OK];
        f.referenced = raw[BIT_REF];
        f.dirty      = raw[BIT_DIRTY];
        return f;
    endfunction

    // Priority: invalid, then absent, then permission
    function automatic fault_e classify(input entry_flags_t f,
                                        input logic is_write,
                                        input logic is_user);
        if (!f.valid)
            return FLT_INVALID;
        else if (!f.present)
            return FLT_ABSENT;
        else if ((is_write && !f.wr_ok) || (is_user && !f.user_ok))
            return FLT_PERM;
        else
            return FLT_NONE;
    endfunction

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned OFS_W = 12,
    parameter int unsigned AW    = 32,
    parameter int unsigned PTE_W = 32
) (
    input  logic [VA_W-1:0]       vaddr,
    input  logic [AW-1:0]         table_base,
    output logic [VA_W-OFS_W-1:0] page_num,
    output logic [OFS_W-1:0]      page_ofs,
    output logic [AW-1:0]         entry_addr
);
    localparam int unsigned PN_W      = VA_W - OFS_W;
    localparam int unsigned ENTRY_SFT = $clog2(PTE_W / 8);

    always_comb begin
        page_num   = vaddr[VA_W-1:OFS_W];
        page_ofs   = vaddr[OFS_W-1:0];
        entry_addr = table_base + (AW'(page_num) << ENTRY_SFT);
    end

    // Unused width marker to keep PN_W meaningful for readers
    logic [PN_W-1:0] pn_unused;
    assign pn_unused = page_num;

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
    import pt_walker_pkg::*;
#(
    parameter int unsigned PTE_W = 32,
    parameter int unsigned OFS_W = 12,
    parameter int unsigned PA_W  = 32
) (
    input  logic [PTE_W-1:0] entry,
    input  logic             is_write,
    input  logic             is_user,
    input  logic [OFS_W-1:0] page_ofs,
    output fault_e           fault,
    output logic [PA_W-1:0]  paddr,
    output logic [PTE_W-1:0] new_entry,
    output logic             need_wb
);
    localparam int unsigned FRAME_W = PA_W - OFS_W;

    entry_flags_t          flags;
    logic [FRAME_W-1:0]    frame;
    logic [PTE_W-1:0]      set_mask;

    // Frame field sits at the top of the entry
    generate
        if (FRAME_W + FLAG_W <= PTE_W) begin : g_frame_top
            assign frame = entry[PTE_W-1 -: FRAME_W];
        end else begin : g_frame_clip
            assign frame = FRAME_W'(entry[PTE_W-1:FLAG_W]);
        end
    endgenerate

    always_comb begin
        flags    = unpack_flags(entry[FLAG_W-1:0]);
        fault    = classify(flags, is_write, is_user);
        paddr    = {frame, page_ofs};
        set_mask = '0;
        set_mask[BIT_REF]   = 1'b1;
        set_mask[BIT_DIRTY] = is_write;
        new_entry = entry | set_mask;
        need_wb   = (fault == FLT_NONE) && (new_entry != entry);
    end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
    import pt_walker_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned PTE_W = 32,
    parameter int unsigned OFS_W = 12,
    parameter int unsigned PA_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    // request side
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_user,
    input  logic [AW-1:0]    req_entry_addr,
    input  logic [OFS_W-1:0] req_ofs,
    // towards the evaluator
    output logic [PTE_W-1:0] entry_q,
    output logic             wr_q,
    output logic             user_q,
    output logic [OFS_W-1:0] ofs_q,
    input  fault_e           eval_fault,
    input  logic [PA_W-1:0]  eval_paddr,
    input  logic [PTE_W-1:0] eval_new_entry,
    input  logic             eval_need_wb,
    // response
    output logic             rsp_valid,
    output fault_e           rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    // memory port
    output logic             mem_req,
    input  logic             mem_gnt,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata
);
    walk_state_e       state;
    logic [AW-1:0]     addr_q;
    logic [PTE_W-1:0]  wb_q;
    fault_e            fault_q;
    logic [PA_W-1:0]   paddr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            ofs_q   <= '0;
            wr_q    <= 1'b0;
            user_q  <= 1'b0;
            entry_q <= '0;
            wb_q    <= '0;
            fault_q <= FLT_NONE;
            paddr_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_entry_addr;
                        ofs_q  <= req_ofs;
                        wr_q   <= req_write;
                        user_q <= req_user;
                        state  <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_gnt) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        entry_q <= mem_rdata;
                        state   <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    fault_q <= eval_fault;
                    paddr_q <= (eval_fault == FLT_NONE) ? eval_paddr : '0;
                    wb_q    <= eval_new_entry;
                    state   <= eval_need_wb ? ST_WRITE : ST_DONE;
                end
                ST_WRITE: begin
                    if (mem_gnt) state <= ST_DONE;
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_DONE);
        rsp_fault = fault_q;
        rsp_paddr = paddr_q;
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = addr_q;
        mem_wdata = wb_q;
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned OFS_W = 12,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned AW    = 32,
    parameter int unsigned PTE_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    table_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic [1:0]       rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             mem_req,
    input  logic             mem_gnt,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata
);
    localparam int unsigned PN_W = VA_W - OFS_W;

    logic [PN_W-1:0]  page_num;
    logic [OFS_W-1:0] page_ofs;
    logic [AW-1:0]    entry_addr;

    logic [PTE_W-1:0] entry_q;
    logic             wr_q;
    logic             user_q;
    logic [OFS_W-1:0] ofs_q;
    fault_e           eval_fault;
    logic [PA_W-1:0]  eval_paddr;
    logic [PTE_W-1:0] eval_new_entry;
    logic             eval_need_wb;
    fault_e           fault_out;

    pt_va_split #(
        .VA_W(VA_W), .OFS_W(OFS_W), .AW(AW), .PTE_W(PTE_W)
    ) u_split (
        .vaddr      (req_vaddr),
        .table_base (table_base),
        .page_num   (page_num),
        .page_ofs   (page_ofs),
        .entry_addr (entry_addr)
    );

    pt_entry_eval #(
        .PTE_W(PTE_W), .OFS_W(OFS_W), .PA_W(PA_W)
    ) u_eval (
        .entry     (entry_q),
        .is_write  (wr_q),
        .is_user   (user_q),
        .page_ofs  (ofs_q),
        .fault     (eval_fault),
        .paddr     (eval_paddr),
        .new_entry (eval_new_entry),
        .need_wb   (eval_need_wb)
    );

    pt_walk_ctrl #(
        .AW(AW), .PTE_W(PTE_W), .OFS_W(OFS_W), .PA_W(PA_W)
    ) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_write      (req_write),
        .req_user       (req_user),
        .req_entry_addr (entry_addr),
        .req_ofs        (page_ofs),
        .entry_q        (entry_q),
        .wr_q           (wr_q),
        .user_q         (user_q),
        .ofs_q          (ofs_q),
        .eval_fault     (eval_fault),
        .eval_paddr     (eval_paddr),
        .eval_new_entry (eval_new_entry),
        .eval_need_wb   (eval_need_wb),
        .rsp_valid      (rsp_valid),
        .rsp_fault      (fault_out),
        .rsp_paddr      (rsp_paddr),
        .mem_req        (mem_req),
        .mem_gnt        (mem_gnt),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_rvalid     (mem_rvalid),
        .mem_rdata      (mem_rdata)
    );

    assign rsp_fault = fault_out;

endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
    parameter int unsigned AW    = 32,
    parameter int unsigned PTE_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [1:0]       rsp_fault,
    input logic             mem_req,
    input logic             mem_gnt,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [PTE_W-1:0] mem_wdata
);
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);                                            // R8

    AST_HOLD_UNTIL_GNT: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R1

    AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[4]);                              // R6

    AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> !$past(mem_req && mem_we));    // R7

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);                                          // R9

    AST_RSP_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mem_req);                                            // R9

endmodule

bind pt_walker pt_walker_checker #(.AW(AW), .PTE_W(PTE_W)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;

    localparam logic [31:0] TBASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_paddr;
    logic        mem_req;
    logic        mem_gnt;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    always #4 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst(rst), .table_base(TBASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem_model [16];
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    int          stall_req = 0;
    int          stall_left;

    assign mem_gnt = mem_req && (stall_left == 0);

    always @(posedge clk) begin
        if (rst) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            stall_left <= 0;
        end else begin
            mem_rvalid <= mem_req && mem_gnt && !mem_we;
            mem_rdata  <= mem_model[mem_addr[5:2]];
            if (mem_req && mem_gnt && mem_we) mem_model[mem_addr[5:2]] <= mem_wdata;
            if (req_valid && req_ready) stall_left <= stall_req;
            else if (mem_req && stall_left != 0) stall_left <= stall_left - 1;
        end
        if (ld_en) mem_model[ld_idx] <= ld_data;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [31:0] rd_addr;
        logic [1:0]  fault;
        logic [31:0] paddr;
        logic        wb;
        logic [31:0] wb_data;
        int          extra;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   acc_cyc = 0;
    int   issued = 0;
    int   responses = 0;
    bit   wb_seen = 1'b0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (req_valid && req_ready) acc_cyc = cyc;
            if (mem_req && mem_gnt) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 memory access with no pending request", mem_addr, 32'h0);
                end else if (!mem_we) begin
                    chk(mem_addr == sb[0].rd_addr, "R1 entry read address", mem_addr, sb[0].rd_addr);
                end else begin
                    wb_seen = 1'b1;
                    chk(sb[0].wb, "R7 unexpected write-back", mem_wdata, sb[0].wb_data);
                    chk(mem_addr == sb[0].rd_addr, "R6 write-back address", mem_addr, sb[0].rd_addr);
                    chk(mem_wdata == sb[0].wb_data, "R6 write-back data", mem_wdata, sb[0].wb_data);
                end
            end
            if (rsp_valid) begin
                responses++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 response with no accepted request", {30'd0, rsp_fault}, 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rsp_fault == e.fault, "R3/R4/R5 fault code", {30'd0, rsp_fault}, {30'd0, e.fault});
                    chk(rsp_paddr == e.paddr, "R2 physical address", rsp_paddr, e.paddr);
                    chk(wb_seen == e.wb, "R7 write-back presence", {31'd0, wb_seen}, {31'd0, e.wb});
                    chk((cyc - acc_cyc) == 4 + e.extra, "R9 response latency",
                        32'(cyc - acc_cyc), 32'(4 + e.extra));
                end
                wb_seen = 1'b0;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic load(input logic [3:0] idx, input logic [31:0] val);
        @(posedge clk); #1;
        ld_en = 1'b1; ld_idx = idx; ld_data = val;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic issue(input logic [31:0] va, input logic wr, input logic usr,
                         input int stall, input bit noise);
        exp_t        e;
        logic [31:0] pte;
        logic [31:0] upd;
        pte = mem_model[va[15:12]];
        e.rd_addr = TBASE + {va[29:12], 2'b00} + {va[31:30], 20'd0};
        if (!pte[0])                               e.fault = 2'd1;
        else if (!pte[1])                          e.fault = 2'd2;
        else if ((wr && !pte[2]) || (usr && !pte[3])) e.fault = 2'd3;
        else                                       e.fault = 2'd0;
        e.paddr   = (e.fault == 2'd0) ? {pte[31:12], va[11:0]} : 32'h0;
        upd       = pte | 32'h10 | (wr ? 32'h20 : 32'h0);
        e.wb      = (e.fault == 2'd0) && (upd != pte);
        e.wb_data = upd;
        e.extra   = stall + (e.wb ? 1 : 0);
        sb.push_back(e);
        issued++;
        @(posedge clk); #1;
        stall_req = stall;
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (noise) begin
            // R8: requests while busy must be dropped
            req_valid = 1'b1; req_vaddr = va ^ 32'h0000_3000; req_write = ~wr;
            @(posedge clk); @(posedge clk); #1;
            req_valid = 1'b0;
        end
        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem_model[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 reset ready", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R9 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk(mem_req == 1'b0, "R1 reset mem_req", {31'd0, mem_req}, 32'd0);

        load(4'd0,  32'hABCDE003);
        load(4'd1,  32'h12345007);
        load(4'd2,  32'h5555503E);
        load(4'd3,  32'h66666001);
        load(4'd4,  32'h77777003);
        load(4'd5,  32'h8888801B);
        load(4'd6,  32'hAAAAA00F);
        load(4'd7,  32'hBBBBB003);
        load(4'd15, 32'h9999903F);

        issue(32'h0000_0123, 1'b0, 1'b0, 0, 1'b0); // R2 R6 read sets referenced
        issue(32'h0000_0456, 1'b0, 1'b0, 0, 1'b0); // R7 already referenced
        issue(32'h0000_1FFF, 1'b1, 1'b0, 0, 1'b0); // R6 write sets dirty
        issue(32'h0000_1000, 1'b1, 1'b0, 0, 1'b0); // R7 nothing to update
        issue(32'h0000_2010, 1'b1, 1'b1, 0, 1'b0); // R3 invalid wins
        issue(32'h0000_3020, 1'b1, 1'b1, 0, 1'b0); // R4 absent over permission
        issue(32'h0000_4030, 1'b1, 1'b0, 0, 1'b0); // R5 write not allowed
        issue(32'h0000_4040, 1'b0, 1'b1, 0, 1'b0); // R5 user not allowed
        issue(32'h0000_5050, 1'b0, 1'b1, 0, 1'b0); // R5 user read allowed
        issue(32'h0000_5060, 1'b1, 1'b1, 0, 1'b0); // R5 user write refused
        issue(32'hFFFF_FABC, 1'b1, 1'b1, 0, 1'b0); // R1 top page number
        issue(32'h0000_6ABC, 1'b1, 1'b0, 3, 1'b0); // R9 grant wait adds edges
        issue(32'h0000_7DEF, 1'b0, 1'b0, 0, 1'b1); // R8 busy request dropped

        // R6 memory image holds the updated entries
        chk(mem_model[0] == 32'hABCDE013, "R6 entry 0 updated", mem_model[0], 32'hABCDE013);
        chk(mem_model[1] == 32'h12345037, "R6 entry 1 updated", mem_model[1], 32'h12345037);
        chk(mem_model[4] == 32'h77777003, "R7 faulted entry untouched", mem_model[4], 32'h77777003);
        chk(responses == issued, "R8 response count", 32'(responses), 32'(issued));

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule